// File: doc/BRIEF.md
# Accumulator ALU with Program Status Flags

This block is the 8-bit arithmetic and logic unit of an accumulator-based control processor, together with the registered status word that holds its flags. Each cycle in which `op_valid` is high, the block applies the operation on `op_code` to the accumulator and the `operand` byte. It then loads the result into the accumulator and updates the carry, auxiliary-carry and overflow flags as that operation defines. The parity flag is not stored. It always reflects the accumulator as it stands.

The status word also holds two register-bank select bits and two general-purpose flags. Software writes these through a separate configuration strobe. The bank bits are joined with a 3-bit register index to form a 5-bit working-register address. The operation port has no back-pressure: the block is always ready and takes one operation in every cycle that `op_valid` is high.

Top module: `acc_alu_top`

## Requirements
- R1: After reset, `acc_q` is 00h and `psw_q` is 00h. With bank 0 selected, `reg_addr` equals the zero-extended `reg_idx`.
- R2: The status word has these fields: bit 7 CY, bit 6 AC, bit 5 user flag 0, bits 4:3 bank select, bit 2 OV, bit 1 user flag 1, bit 0 P. ADD (code 0) computes A + B. ADDC (code 1) computes A + B + CY. Both set CY to the carry out of bit 7, AC to the carry out of bit 3, and OV to the XOR of the carries into and out of bit 7.
- R3: SUBB (code 2) always computes A − B − CY. It sets CY to the borrow out of bit 7, AC to the borrow out of bit 3, and OV to the XOR of the borrows into and out of bit 7.
- R4: The following operations change A but leave CY, AC and OV unchanged: INC (3), DEC (4), AND (5), OR (6), XOR (7), CLR (8, A becomes 00h) and CPL (9, A becomes the bitwise complement).
- R5: RL (10) moves bit 7 to bit 0. RR (12) moves bit 0 to bit 7. Neither changes any flag. RLC (11) shifts CY into bit 0 and bit 7 into CY. RRC (13) shifts CY into bit 7 and bit 0 into CY.
- R6: SWAP (14) exchanges the two nibbles of A and changes no flag.
- R7: DA (15) first adds 06h when the low nibble exceeds 9 or AC is 1. It then adds 60h when the high nibble exceeds 9 or CY is 1. It sets CY when either addition carries out of bit 7, never clears CY, and leaves AC and OV unchanged.
- R8: CMP (16) sets CY when A is less than B as unsigned bytes and clears it otherwise. It does not change A, AC or OV.
- R9: P equals 1 exactly when `acc_q` holds an odd number of ones, so that the ones in `acc_q` plus P are always even.
- R10: LOAD (17) copies B into A and changes no flag.
- R11: A cycle with `cfg_we` high loads `cfg_bank` into bits 4:3, `cfg_f0` into bit 5 and `cfg_f1` into bit 1. Operations never change these bits. `reg_addr` equals {bank, `reg_idx`}, so the bank bases are 00h, 08h, 10h and 18h.
- R12: When `op_valid` is low, or when `op_code` holds a value from 18 to 31, the accumulator and all flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Apply `op_code` in this cycle |
| op_code | input | 5 | Operation code |
| operand | input | 8 | Second operand byte B |
| cfg_we | input | 1 | Write bank and user flags |
| cfg_bank | input | 2 | Register bank to select |
| cfg_f0 | input | 1 | User flag 0 value |
| cfg_f1 | input | 1 | User flag 1 value |
| reg_idx | input | 3 | Working register index |
| acc_q | output | 8 | Accumulator |
| psw_q | output | 8 | Program status word |
| reg_addr | output | 5 | Working register address |

## Verification
An operation presented with `op_valid` is registered at the next rising edge. Its result appears on `acc_q` and `psw_q` one cycle after it is presented. Parity follows the accumulator in the same cycle, so it is due together with the result. A configuration write also reaches `psw_q` after one edge, and `reg_addr` follows combinationally one cycle after the write. The bench drives every input on a falling edge and reads the outputs on the next falling edge, half a period after the edge that registered them.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW    = 8;
  localparam int NW    = DW / 2;
  localparam int OPW   = 5;
  localparam int BANKW = 2;
  localparam int IDXW  = 3;
  localparam int RAW   = BANKW + IDXW;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_CLR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_RL   = 5'd10,
    OP_RLC  = 5'd11,
    OP_RR   = 5'd12,
    OP_RRC  = 5'd13,
    OP_SWAP = 5'd14,
    OP_DA   = 5'd15,
    OP_CMP  = 5'd16,
    OP_LOAD = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output alu_flags_t    flags
);
  logic [NW:0] lo;
  logic [DW-1:0] mid;
  logic [DW:0] full;

  always_comb begin
    if (sub) begin
      lo   = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, cin};
      mid  = {1'b0, a[DW-2:0]} - {1'b0, b[DW-2:0]} - {{(DW-1){1'b0}}, cin};
      full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    end else begin
      lo   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, cin};
      mid  = {1'b0, a[DW-2:0]} + {1'b0, b[DW-2:0]} + {{(DW-1){1'b0}}, cin};
      full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    end
    sum      = full[DW-1:0];
    flags.cy = full[DW];
    flags.ac = lo[NW];
    flags.ov = mid[DW-1] ^ full[DW];
  end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic          cy_in,
  input  logic          ac_in,
  output logic [DW-1:0] res,
  output logic          cy_out
);
  localparam logic [NW-1:0] DIGIT_MAX = NW'(9);
  localparam logic [DW:0]   LO_FIX    = (DW+1)'(6);
  localparam logic [DW:0]   HI_FIX    = (DW+1)'(6) << NW;

  logic [DW:0] step1;
  logic [DW:0] step2;
  logic        c1;

  always_comb begin
    step1  = {1'b0, a} + (((a[NW-1:0] > DIGIT_MAX) || ac_in) ? LO_FIX : '0);
    c1     = cy_in | step1[DW];
    step2  = {1'b0, step1[DW-1:0]} +
             (((step1[DW-1:NW] > DIGIT_MAX) || c1) ? HI_FIX : '0);
    res    = step2[DW-1:0];
    cy_out = c1 | step2[DW];
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  alu_flags_t     fl_in,
  output logic [DW-1:0]  res,
  output alu_flags_t     fl_out
);
  logic          as_sub;
  logic          as_cin;
  logic [DW-1:0] as_sum;
  alu_flags_t    as_fl;
  logic [DW-1:0] da_res;
  logic          da_cy;

  assign as_sub = (op == OP_SUBB);
  assign as_cin = (op == OP_ADD) ? 1'b0 : fl_in.cy;

  acc_alu_addsub u_addsub (
    .a(a), .b(b), .cin(as_cin), .sub(as_sub), .sum(as_sum), .flags(as_fl)
  );

  acc_alu_decadj u_decadj (
    .a(a), .cy_in(fl_in.cy), .ac_in(fl_in.ac), .res(da_res), .cy_out(da_cy)
  );

  always_comb begin
    res    = a;
    fl_out = fl_in;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        res    = as_sum;
        fl_out = as_fl;
      end
      OP_INC:  res = a + DW'(1);
      OP_DEC:  res = a - DW'(1);
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CLR:  res = '0;
      OP_CPL:  res = ~a;
      OP_RL:   res = {a[DW-2:0], a[DW-1]};
      OP_RR:   res = {a[0], a[DW-1:1]};
      OP_RLC: begin
        res       = {a[DW-2:0], fl_in.cy};
        fl_out.cy = a[DW-1];
      end
      OP_RRC: begin
        res       = {fl_in.cy, a[DW-1:1]};
        fl_out.cy = a[0];
      end
      OP_SWAP: res = {a[NW-1:0], a[DW-1:NW]};
      OP_DA: begin
        res       = da_res;
        fl_out.cy = da_cy;
      end
      OP_CMP:  fl_out.cy = (a < b);
      OP_LOAD: res = b;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_state.sv
module acc_alu_state
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [DW-1:0]    nxt_acc,
  input  alu_flags_t       nxt_fl,
  input  logic             cfg_we,
  input  logic [BANKW-1:0] cfg_bank,
  input  logic             cfg_f0,
  input  logic             cfg_f1,
  output logic [DW-1:0]    acc,
  output alu_flags_t       fl,
  output logic [BANKW-1:0] bank,
  output logic [DW-1:0]    psw
);
  logic f0;
  logic f1;
  logic par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      fl  <= '0;
    end else if (op_valid) begin
      acc <= nxt_acc;
      fl  <= nxt_fl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0;
      f0   <= 1'b0;
      f1   <= 1'b0;
    end else if (cfg_we) begin
      bank <= cfg_bank;
      f0   <= cfg_f0;
      f1   <= cfg_f1;
    end
  end

  assign par = ^acc;
  assign psw = {fl.cy, fl.ac, f0, bank, fl.ov, f1, par};
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OPW-1:0]   op_code,
  input  logic [DW-1:0]    operand,
  input  logic             cfg_we,
  input  logic [BANKW-1:0] cfg_bank,
  input  logic             cfg_f0,
  input  logic             cfg_f1,
  input  logic [IDXW-1:0]  reg_idx,
  output logic [DW-1:0]    acc_q,
  output logic [DW-1:0]    psw_q,
  output logic [RAW-1:0]   reg_addr
);
  logic [DW-1:0]    res;
  alu_flags_t       fl_cur;
  alu_flags_t       fl_nxt;
  logic [BANKW-1:0] bank;

  acc_alu_core u_core (
    .op(op_code), .a(acc_q), .b(operand), .fl_in(fl_cur),
    .res(res), .fl_out(fl_nxt)
  );

  acc_alu_state u_state (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
    .nxt_acc(res), .nxt_fl(fl_nxt),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_f0(cfg_f0), .cfg_f1(cfg_f1),
    .acc(acc_q), .fl(fl_cur), .bank(bank), .psw(psw_q)
  );

  assign reg_addr = {bank, reg_idx};
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [OPW-1:0]   op_code,
  input logic             cfg_we,
  input logic [BANKW-1:0] cfg_bank,
  input logic [DW-1:0]    acc_q,
  input logic [DW-1:0]    psw_q
);
  logic keeps_flags;
  assign keeps_flags = op_valid && (op_code >= OP_INC) && (op_code <= OP_CPL);

  // R9
  even_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({acc_q, psw_q[0]}) % 2) == 0);

  // R8
  cmp_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |=> $stable(acc_q));

  // R4
  logic_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keeps_flags |=> ($stable(psw_q[7:6]) && $stable(psw_q[2])));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(acc_q));

  // R11
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (psw_q[4:3] == $past(cfg_bank)));

  // R7
  da_carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_DA && psw_q[7]) |=> psw_q[7]);
endmodule

bind acc_alu_top acc_alu_chk i_acc_alu_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .cfg_we(cfg_we), .cfg_bank(cfg_bank), .acc_q(acc_q), .psw_q(psw_q)
);

// File: tb/test_acc_alu_top.sv
module test_acc_alu_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] operand = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_bank = '0;
  logic       cfg_f0 = 1'b0;
  logic       cfg_f1 = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [7:0] acc_q;
  logic [7:0] psw_q;
  logic [4:0] reg_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [4:0] ADD=0, ADDC=1, SUBB=2, INC=3, DEC=4, AND_=5, OR_=6,
    XOR_=7, CLR=8, CPL=9, RL=10, RLC=11, RR=12, RRC=13, SWAP=14, DA=15,
    CMP=16, LOAD=17;

  always #5 clk = ~clk;

  acc_alu_top i_acc_alu_top (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_f0(cfg_f0),
    .cfg_f1(cfg_f1), .reg_idx(reg_idx), .acc_q(acc_q), .psw_q(psw_q),
    .reg_addr(reg_addr)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic op(logic [4:0] code, logic [7:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; operand = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic expect_state(string req, logic [7:0] a, logic [7:0] p);
    check(req, "acc", acc_q, a);
    check(req, "psw", psw_q, p);
  endtask

  task automatic t_reset;
    check("R1", "acc", acc_q, 8'h00);
    check("R1", "psw", psw_q, 8'h00);
    reg_idx = 3'd6;
    #1 check("R1", "reg_addr", {3'b0, reg_addr}, 8'h06);
  endtask

  task automatic t_add;
    op(LOAD, 8'h3A); expect_state("R10", 8'h3A, 8'h00);
    op(ADD, 8'h27);  expect_state("R2", 8'h61, 8'h41);
    op(LOAD, 8'h7F); op(ADD, 8'h01); expect_state("R2", 8'h80, 8'h45);
    op(LOAD, 8'hFF); op(ADD, 8'h01); expect_state("R2", 8'h00, 8'hC0);
    op(LOAD, 8'h10); op(ADDC, 8'h20); expect_state("R2", 8'h31, 8'h01);
  endtask

  task automatic t_subb;
    op(CMP, 8'h40);  expect_state("R8", 8'h31, 8'h81);
    op(SUBB, 8'h01); expect_state("R3", 8'h2F, 8'h41);
    op(LOAD, 8'h80); op(SUBB, 8'h01); expect_state("R3", 8'h7F, 8'h45);
    op(LOAD, 8'h00); op(SUBB, 8'h01); expect_state("R3", 8'hFF, 8'hC0);
  endtask

  task automatic t_keep_flags;
    op(INC, 8'h00);  expect_state("R4", 8'h00, 8'hC0);
    op(DEC, 8'h00);  expect_state("R4", 8'hFF, 8'hC0);
    op(LOAD, 8'h35); op(AND_, 8'h53); expect_state("R4", 8'h11, 8'hC0);
    op(OR_, 8'h0C);  expect_state("R4", 8'h1D, 8'hC0);
    op(XOR_, 8'hFF); expect_state("R4", 8'hE2, 8'hC0);
    op(CPL, 8'h00);  expect_state("R4", 8'h1D, 8'hC0);
    op(CLR, 8'h00);  expect_state("R4", 8'h00, 8'hC0);
  endtask

  task automatic t_rotate;
    op(LOAD, 8'h81);
    op(RL, 8'h00);  expect_state("R5", 8'h03, 8'hC0);
    op(RR, 8'h00);  expect_state("R5", 8'h81, 8'hC0);
    op(RR, 8'h00);  expect_state("R5", 8'hC0, 8'hC0);
    op(CMP, 8'h00); expect_state("R8", 8'hC0, 8'h40);
    op(RLC, 8'h00); expect_state("R5", 8'h80, 8'hC1);
    op(RRC, 8'h00); expect_state("R5", 8'hC0, 8'h40);
  endtask

  task automatic t_swap;
    op(LOAD, 8'h5A); op(SWAP, 8'h00); expect_state("R6", 8'hA5, 8'h40);
  endtask

  task automatic t_decadj;
    op(LOAD, 8'h38); op(ADD, 8'h49); expect_state("R2", 8'h81, 8'h44);
    op(DA, 8'h00);   expect_state("R7", 8'h87, 8'h44);
    op(LOAD, 8'h99); op(ADD, 8'h01); expect_state("R2", 8'h9A, 8'h00);
    op(DA, 8'h00);   expect_state("R7", 8'h00, 8'h80);
    op(LOAD, 8'h12); op(DA, 8'h00); expect_state("R7", 8'h72, 8'h80);
  endtask

  task automatic t_compare;
    op(CMP, 8'h72); expect_state("R8", 8'h72, 8'h00);
    op(CMP, 8'h90); expect_state("R8", 8'h72, 8'h80);
    op(CMP, 8'h05); expect_state("R8", 8'h72, 8'h00);
  endtask

  task automatic t_parity;
    op(LOAD, 8'h01); check("R9", "parity", {7'b0, psw_q[0]}, 8'h01);
    op(LOAD, 8'h03); check("R9", "parity", {7'b0, psw_q[0]}, 8'h00);
    op(LOAD, 8'hFE); check("R9", "parity", {7'b0, psw_q[0]}, 8'h01);
  endtask

  task automatic t_bank;
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 2'd2; cfg_f0 = 1'b1; cfg_f1 = 1'b1; reg_idx = 3'd5;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11", "psw bank/user", psw_q & 8'h3A, 8'h32);
    check("R11", "reg_addr", {3'b0, reg_addr}, 8'h15);
    op(ADD, 8'h11);
    check("R11", "bank kept", psw_q & 8'h3A, 8'h32);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 2'd3; cfg_f0 = 1'b0; cfg_f1 = 1'b0; reg_idx = 3'd7;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11", "psw bank/user", psw_q & 8'h3A, 8'h18);
    check("R11", "reg_addr", {3'b0, reg_addr}, 8'h1F);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 2'd1; reg_idx = 3'd0;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11", "reg_addr", {3'b0, reg_addr}, 8'h08);
  endtask

  task automatic t_ignore;
    logic [7:0] p0;
    op(LOAD, 8'h5A);
    p0 = psw_q;
    @(negedge clk);
    op_valid = 1'b0; op_code = LOAD; operand = 8'hFF;
    @(negedge clk);
    expect_state("R12", 8'h5A, p0);
    op(5'd18, 8'h00); expect_state("R12", 8'h5A, p0);
    op(5'd31, 8'hFF); expect_state("R12", 8'h5A, p0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    reg_idx = 3'd0;
    t_add();
    t_subb();
    t_keep_flags();
    t_rotate();
    t_swap();
    t_decadj();
    t_compare();
    t_parity();
    t_bank();
    t_ignore();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule